// File: doc/BRIEF.md
# UART FIFO Pair with Level Interrupts

This block sits between a UART's host side and its serial engines. It buffers characters for transmission and holds received characters together with their error status. It also raises interrupts when the fill level crosses a programmable mark, when received data goes stale, or when a character arrives with an error. The serializer and deserializer are separate blocks. The serializer pulls bytes through a valid/ready port and reports when it is still shifting. The deserializer pushes characters with its error flags and a bit-period tick.

The transmit path uses valid/ready on both sides. A beat moves only in a cycle where valid and ready are both high. A producer holds valid and data steady until it sees ready. The receive input has no ready signal, because a line cannot be stalled. A character that arrives while the receive FIFO is full is dropped and reported as an overrun. All interrupt sources are latched in a raw vector. A per-bit mask gives the masked vector, and the masked bits are ORed onto one interrupt line. Software clears a bit by pulsing a 1 on the matching clear input. That single clear acts on both views, since the masked view is derived from the raw one.

Top module: `uart_fifo_irq`

## Requirements
- R1: With `cfg_fifo_en` high, the transmit FIFO holds DEPTH (16) bytes and returns them in order. `tx_in_ready` is low when it is full, and `tx_out_valid` is high while it holds at least one byte.
- R2: The receive FIFO stores 12-bit entries: bit 11 overrun, bit 10 break, bit 9 parity error, bit 8 framing error, bits 7:0 data. `rx_in_err` carries {break, parity, framing} as bits 2, 1, 0.
- R3: With `cfg_fifo_en` low (the state after reset), each FIFO has a capacity of exactly one entry.
- R4: In a cycle where `cfg_fifo_en` is low but was high in the previous cycle, both FIFOs are emptied. `tx_in_ready` is low in that cycle, and a receive character arriving in that cycle is discarded without any interrupt.
- R5: Level codes on `cfg_tx_lvl` and `cfg_rx_lvl` are: 0 = 1/2, 1 = 1/8, 2 = 1/4, 3 = 3/4, 4 = 7/8 of DEPTH. Codes 5 to 7 act as 1/2. With FIFOs off, the receive mark is 1 and the transmit mark is 0.
- R6: Raw bit 0 (receive level) sets when a stored character with no pop in the same cycle raises the receive fill from mark-1 to the mark. For example, the 12th entry at 3/4.
- R7: Raw bit 1 (transmit level) sets when a pop with no push in the same cycle lowers the transmit fill from mark+1 to the mark.
- R8: A character arriving while the receive FIFO is full is dropped and sets raw bit 6 (overrun). The next stored entry carries bit 11 set, and the flag is then consumed.
- R9: A stored character sets raw bit 3 if its framing flag is set, raw bit 4 if its parity flag is set, and raw bit 5 if its break flag is set.
- R10: Raw bit 2 (timeout) sets on the `rx_bit_tick` that completes TO_LIMIT (32) consecutive ticks with the receive FIFO non-empty and no `rx_in_valid`. Any arrival or an empty FIFO restarts the count.
- R11: Raw bit 2 clears in the cycle after the receive FIFO is seen empty, or after a clear pulse on `irq_clr[2]`.
- R12: A 1 on `irq_clr[i]` clears raw bit i on the next edge, unless bit i is set in that same cycle, in which case the set wins. `irq_masked` = `irq_raw & irq_mask`, and `irq` is the OR of `irq_masked`.
- R13: `tx_empty`, `tx_full`, `rx_empty` and `rx_full` reflect fill versus current capacity. `busy` is high while the transmit FIFO is non-empty or `tx_shift_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fifo_en | input | 1 | 1 = 16-deep FIFOs, 0 = one-entry holding registers |
| cfg_tx_lvl | input | 3 | Transmit level mark code |
| cfg_rx_lvl | input | 3 | Receive level mark code |
| irq_mask | input | 7 | Per-source interrupt enable |
| irq_clr | input | 7 | Write-1-to-clear pulses per source |
| tx_in_valid | input | 1 | Host offers a byte |
| tx_in_ready | output | 1 | Transmit FIFO accepts the byte |
| tx_in_data | input | 8 | Byte to transmit |
| tx_out_valid | output | 1 | Head byte available to the serializer |
| tx_out_ready | input | 1 | Serializer takes the head byte |
| tx_out_data | output | 8 | Head byte of the transmit FIFO |
| tx_shift_busy | input | 1 | Serializer still shifting a character |
| rx_in_valid | input | 1 | Deserializer delivers a character |
| rx_in_data | input | 8 | Received data bits |
| rx_in_err | input | 3 | {break, parity, framing} flags of the character |
| rx_bit_tick | input | 1 | One pulse per bit period |
| rx_out_valid | output | 1 | Receive FIFO holds an entry |
| rx_out_ready | input | 1 | Host takes the head entry |
| rx_out_data | output | 12 | Head entry with status bits |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| busy | output | 1 | Transmit path busy |
| irq_raw | output | 7 | Latched interrupt sources |
| irq_masked | output | 7 | Raw sources gated by mask |
| irq | output | 1 | OR of masked sources |

## Verification
The collision that matters most is a software clear of an error bit landing in the same cycle as a new errored character that sets that bit again. A second one is a drain to empty landing together with the timeout tick. The directed phase pushes a character with all three error flags while clear pulses are applied to those bits. It then lets the timeout mature and drains the FIFO under running ticks. The behavioural model applies set-over-clear and the empty-driven timeout clear, and it compares every raw bit on every cycle. A long random phase then overlaps pushes, pops, clears, mode flushes and level changes.

// File: rtl/ufi_pkg.sv
package ufi_pkg;

  localparam int DATA_W = 8;
  localparam int IRQ_W  = 7;

  // raw interrupt bit positions
  localparam int IB_RXL = 0;
  localparam int IB_TXL = 1;
  localparam int IB_TO  = 2;
  localparam int IB_FRM = 3;
  localparam int IB_PAR = 4;
  localparam int IB_BRK = 5;
  localparam int IB_OVR = 6;

  typedef enum logic [2:0] {
    LVL_HALF    = 3'd0,
    LVL_EIGHTH  = 3'd1,
    LVL_QUARTER = 3'd2,
    LVL_3QUART  = 3'd3,
    LVL_7EIGHTH = 3'd4
  } lvl_code_e;

  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              par;
    logic              frm;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // fill mark in eighths of the depth
  function automatic int unsigned lvl_eighths(input logic [2:0] code);
    case (code)
      LVL_EIGHTH:  return 1;
      LVL_QUARTER: return 2;
      LVL_3QUART:  return 6;
      LVL_7EIGHTH: return 7;
      default:     return 4;
    endcase
  endfunction

  function automatic int unsigned lvl_entries(input logic [2:0] code, input int unsigned depth);
    return (depth * lvl_eighths(code)) / 8;
  endfunction

endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             deep,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = deep ? (count >= CW'(DEPTH)) : (count != '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty);

endmodule

// File: rtl/ufi_rx_timeout.sv
module ufi_rx_timeout #(
  parameter int LIMIT = 32,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic empty,
  input  logic tick,
  output logic evt
);

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              quiet_cnt <= '0;
    else if (arrive || empty)                quiet_cnt <= '0;
    else if (tick && quiet_cnt < CW'(LIMIT)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign evt = !arrive && !empty && tick && (quiet_cnt == CW'(LIMIT - 1));

  // R10
  arrive_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n) arrive |=> !evt);

endmodule

// File: rtl/ufi_irq_regs.sv
module ufi_irq_regs #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] hw_clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] raw,
  output logic [W-1:0] masked,
  output logic         irq
);

  logic [W-1:0] raw_d;

  always_comb begin
    for (int b = 0; b < W; b++)
      raw_d[b] = set[b] | (raw[b] & ~clr[b] & ~hw_clr[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_d;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  for (genvar b = 0; b < W; b++) begin : g_chk
    // R12
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[b] && !set[b]) |=> !raw[b]);
    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[b] |=> raw[b]);
  end

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import ufi_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fifo_en,
  input  logic [2:0]        cfg_tx_lvl,
  input  logic [2:0]        cfg_rx_lvl,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic [IRQ_W-1:0]  irq_clr,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_shift_busy,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic [2:0]        rx_in_err,
  input  logic              rx_bit_tick,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W+3:0] rx_out_data,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              busy,
  output logic [IRQ_W-1:0]  irq_raw,
  output logic [IRQ_W-1:0]  irq_masked,
  output logic              irq
);

  localparam int CW  = $clog2(DEPTH + 1);
  localparam int RXW = DATA_W + 4;

  logic          fifo_en_q, flush;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_thr, rx_thr;
  logic          tx_push, tx_pop, rx_store, rx_pop, ovr_hit, ovr_pend;
  logic          to_evt;
  rx_entry_t     rx_entry;
  logic [IRQ_W-1:0] irq_set, irq_hw_clr;

  // mode tracking: a falling enable flushes both queues
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_en_q <= 1'b0;
    else        fifo_en_q <= cfg_fifo_en;
  end
  assign flush = fifo_en_q && !cfg_fifo_en;

  // fill marks
  always_comb begin
    if (cfg_fifo_en) begin
      tx_thr = CW'(lvl_entries(cfg_tx_lvl, DEPTH));
      rx_thr = CW'(lvl_entries(cfg_rx_lvl, DEPTH));
    end else begin
      tx_thr = '0;
      rx_thr = CW'(1);
    end
  end

  // transmit side
  assign tx_in_ready  = !tx_full && !flush;
  assign tx_push      = tx_in_valid && tx_in_ready;
  assign tx_out_valid = !tx_empty;
  assign tx_pop       = tx_out_valid && tx_out_ready;
  assign busy         = !tx_empty || tx_shift_busy;

  ufi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .deep  (cfg_fifo_en),
    .push  (tx_push),
    .pop   (tx_pop),
    .flush (flush),
    .wdata (tx_in_data),
    .rdata (tx_out_data),
    .count (tx_cnt),
    .empty (tx_empty),
    .full  (tx_full)
  );

  // receive side
  assign rx_store     = rx_in_valid && !rx_full && !flush;
  assign ovr_hit      = rx_in_valid &&  rx_full && !flush;
  assign rx_out_valid = !rx_empty;
  assign rx_pop       = rx_out_valid && rx_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr_pend <= 1'b0;
    else if (flush)    ovr_pend <= 1'b0;
    else if (ovr_hit)  ovr_pend <= 1'b1;
    else if (rx_store) ovr_pend <= 1'b0;
  end

  always_comb begin
    rx_entry.ovr  = ovr_pend;
    rx_entry.brk  = rx_in_err[2];
    rx_entry.par  = rx_in_err[1];
    rx_entry.frm  = rx_in_err[0];
    rx_entry.data = rx_in_data;
  end

  ufi_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .deep  (cfg_fifo_en),
    .push  (rx_store),
    .pop   (rx_pop),
    .flush (flush),
    .wdata (rx_entry),
    .rdata (rx_out_data),
    .count (rx_cnt),
    .empty (rx_empty),
    .full  (rx_full)
  );

  ufi_rx_timeout #(.LIMIT(TO_LIMIT)) u_rx_to (
    .clk    (clk),
    .rst_n  (rst_n),
    .arrive (rx_in_valid),
    .empty  (rx_empty),
    .tick   (rx_bit_tick),
    .evt    (to_evt)
  );

  // interrupt sources
  always_comb begin
    irq_set         = '0;
    irq_set[IB_RXL] = !flush && rx_store && !rx_pop && (rx_cnt == rx_thr - CW'(1));
    irq_set[IB_TXL] = !flush && tx_pop && !tx_push && (tx_cnt == tx_thr + CW'(1));
    irq_set[IB_TO]  = to_evt;
    irq_set[IB_FRM] = rx_store && rx_in_err[0];
    irq_set[IB_PAR] = rx_store && rx_in_err[1];
    irq_set[IB_BRK] = rx_store && rx_in_err[2];
    irq_set[IB_OVR] = ovr_hit;
    irq_hw_clr        = '0;
    irq_hw_clr[IB_TO] = rx_empty;
  end

  ufi_irq_regs #(.W(IRQ_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (irq_set),
    .clr    (irq_clr),
    .hw_clr (irq_hw_clr),
    .mask   (irq_mask),
    .raw    (irq_raw),
    .masked (irq_masked),
    .irq    (irq)
  );

  // R3
  bypass_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en_q && !cfg_fifo_en) |-> (tx_cnt <= CW'(1) && rx_cnt <= CW'(1)));
  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_full && !flush) |=> irq_raw[IB_OVR]);
  // R11
  drain_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |=> !irq_raw[IB_TO]);

endmodule

// File: tb/uart_fifo_irq_tb_top.sv
module uart_fifo_irq_tb_top;
  import ufi_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int TO_LIMIT   = 32;

  logic clk, rst_n;
  logic cfg_fifo_en;
  logic [2:0] cfg_tx_lvl, cfg_rx_lvl;
  logic [6:0] irq_mask, irq_clr;
  logic tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready, tx_shift_busy;
  logic [7:0] tx_in_data, tx_out_data;
  logic rx_in_valid, rx_bit_tick, rx_out_valid, rx_out_ready;
  logic [7:0] rx_in_data;
  logic [2:0] rx_in_err;
  logic [11:0] rx_out_data;
  logic tx_empty, tx_full, rx_empty, rx_full, busy, irq;
  logic [6:0] irq_raw, irq_masked;

  uart_fifo_irq #(.DEPTH(DEPTH), .TO_LIMIT(TO_LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en),
    .cfg_tx_lvl(cfg_tx_lvl), .cfg_rx_lvl(cfg_rx_lvl),
    .irq_mask(irq_mask), .irq_clr(irq_clr),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_shift_busy(tx_shift_busy),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_err(rx_in_err),
    .rx_bit_tick(rx_bit_tick),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
    .busy(busy), .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference state
  logic [7:0]  m_txq[$];
  logic [11:0] m_rxq[$];
  bit          m_en_q;
  bit          m_ovp;
  int          m_quiet;
  logic [6:0]  m_raw;
  int checks = 0;
  int errors = 0;
  string raw_tag[7] = '{"R5/R6 R12", "R5/R7 R12", "R10/R11 R12", "R9 R12", "R9 R12", "R9 R12", "R8 R12"};

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int mark_of(input bit en, input logic [2:0] code, input bit is_rx);
    int k;
    if (!en) return is_rx ? 1 : 0;
    case (code)
      3'd1: k = 1;
      3'd2: k = 2;
      3'd3: k = 6;
      3'd4: k = 7;
      default: k = 4;
    endcase
    return DEPTH * k / 8;
  endfunction

  // one clock: compare at current inputs, advance model, wait an edge
  task automatic cycle();
    bit flush, tx_rdy, tx_push, tx_pop, rx_full_e, rx_store, ovr, rx_pop;
    int cap, txs, rxs;
    logic [6:0] set, nraw;
    #1;
    txs   = m_txq.size();
    rxs   = m_rxq.size();
    flush = m_en_q && !cfg_fifo_en;
    cap   = cfg_fifo_en ? DEPTH : 1;
    tx_rdy = (txs < cap) && !flush;
    rx_full_e = (rxs >= cap);

    chk("R1/R3/R4", "tx_in_ready", 32'(tx_in_ready), 32'(tx_rdy));
    chk("R1", "tx_out_valid", 32'(tx_out_valid), 32'(txs > 0));
    if (txs > 0) chk("R1", "tx_out_data", 32'(tx_out_data), 32'(m_txq[0]));
    chk("R2", "rx_out_valid", 32'(rx_out_valid), 32'(rxs > 0));
    if (rxs > 0) chk("R2/R8", "rx_out_data", 32'(rx_out_data), 32'(m_rxq[0]));
    chk("R13", "tx_empty", 32'(tx_empty), 32'(txs == 0));
    chk("R13", "tx_full", 32'(tx_full), 32'(txs >= cap));
    chk("R13", "rx_empty", 32'(rx_empty), 32'(rxs == 0));
    chk("R3 R13", "rx_full", 32'(rx_full), 32'(rx_full_e));
    chk("R13", "busy", 32'(busy), 32'((txs > 0) || tx_shift_busy));
    for (int b = 0; b < 7; b++)
      chk(raw_tag[b], $sformatf("irq_raw[%0d]", b), 32'(irq_raw[b]), 32'(m_raw[b]));
    chk("R12", "irq_masked", 32'(irq_masked), 32'(m_raw & irq_mask));
    chk("R12", "irq", 32'(irq), 32'(|(m_raw & irq_mask)));

    tx_push  = tx_in_valid && tx_rdy;
    tx_pop   = (txs > 0) && tx_out_ready;
    rx_store = rx_in_valid && !rx_full_e && !flush;
    ovr      = rx_in_valid && rx_full_e && !flush;
    rx_pop   = (rxs > 0) && rx_out_ready;

    set = '0;
    if (!flush) begin
      if (rx_store && !rx_pop && rxs == mark_of(cfg_fifo_en, cfg_rx_lvl, 1'b1) - 1) set[0] = 1'b1;
      if (tx_pop && !tx_push && txs == mark_of(cfg_fifo_en, cfg_tx_lvl, 1'b0) + 1) set[1] = 1'b1;
    end
    if (!rx_in_valid && rxs > 0 && rx_bit_tick && m_quiet == TO_LIMIT - 1) set[2] = 1'b1;
    if (rx_store) begin
      set[3] = rx_in_err[0];
      set[4] = rx_in_err[1];
      set[5] = rx_in_err[2];
    end
    if (ovr) set[6] = 1'b1;

    if (rx_in_valid || rxs == 0) m_quiet = 0;
    else if (rx_bit_tick && m_quiet < TO_LIMIT) m_quiet++;

    for (int b = 0; b < 7; b++)
      nraw[b] = set[b] | (m_raw[b] & !irq_clr[b] & !((b == 2) && (rxs == 0)));
    m_raw = nraw;

    if (flush) begin
      m_txq.delete();
      m_rxq.delete();
      m_ovp = 1'b0;
    end else begin
      if (tx_pop) void'(m_txq.pop_front());
      if (tx_push) m_txq.push_back(tx_in_data);
      if (rx_pop) void'(m_rxq.pop_front());
      if (rx_store) begin
        m_rxq.push_back({m_ovp, rx_in_err, rx_in_data});
        m_ovp = 1'b0;
      end
      if (ovr) m_ovp = 1'b1;
    end
    m_en_q = cfg_fifo_en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    tx_in_valid = 0; tx_out_ready = 0; tx_shift_busy = 0;
    rx_in_valid = 0; rx_bit_tick = 0; rx_out_ready = 0;
    irq_clr = '0; rx_in_err = '0;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired act=%0d exp=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 0; cfg_fifo_en = 0; cfg_tx_lvl = 0; cfg_rx_lvl = 0;
    irq_mask = '0; tx_in_data = '0; rx_in_data = '0;
    idle_inputs();
    m_en_q = 0; m_ovp = 0; m_quiet = 0; m_raw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cycle(); // reset state

    // bypass mode: one-entry holding registers (R3)
    tx_in_valid = 1; tx_in_data = 8'hA5; cycle();
    tx_in_data = 8'h3C; cycle();
    tx_out_ready = 1; cycle();
    cycle();
    tx_in_valid = 0; cycle();
    tx_out_ready = 0;
    rx_in_valid = 1; rx_in_data = 8'h11; cycle();
    rx_in_data = 8'h22; cycle();                 // R8 overrun
    rx_in_valid = 0; rx_out_ready = 1; cycle();
    rx_out_ready = 0; rx_in_valid = 1; rx_in_data = 8'h33; rx_in_err = 3'b101; cycle();
    rx_in_valid = 0; rx_in_err = 0; cycle();
    irq_mask = 7'h7F; cycle();
    irq_clr = 7'h7F; cycle();
    irq_clr = 0; rx_out_ready = 1; cycle();
    rx_out_ready = 0; cycle();

    // FIFO mode, receive mark 3/4 (R5, R6)
    cfg_fifo_en = 1; cfg_rx_lvl = 3'd3; irq_mask = 7'h05;
    for (int i = 0; i < 14; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(i + 8'h50); rx_in_err = 3'(i); cycle();
    end
    // clear and new error in the same cycle: set wins (R12)
    irq_clr = 7'h39; rx_in_data = 8'hEE; rx_in_err = 3'b111; cycle();
    irq_clr = 0; rx_in_valid = 0; rx_in_err = 0; cycle();

    // receive timeout (R10, R11)
    for (int j = 0; j < 150; j++) begin rx_bit_tick = (j % 4 == 0); cycle(); end
    rx_bit_tick = 0; irq_clr = 7'h04; cycle();
    irq_clr = 0;
    for (int j = 0; j < 140; j++) begin rx_bit_tick = (j % 4 == 0); cycle(); end
    rx_out_ready = 1;
    for (int j = 0; j < 24; j++) begin rx_bit_tick = (j % 2 == 0); cycle(); end
    rx_out_ready = 0; rx_bit_tick = 0; cycle();

    // transmit fill and drain, mark 1/8 (R7)
    cfg_tx_lvl = 3'd1;
    for (int i = 0; i < 18; i++) begin tx_in_valid = 1; tx_in_data = 8'(8'h40 + i); cycle(); end
    tx_in_valid = 0; tx_shift_busy = 1;
    for (int i = 0; i < 40; i++) begin tx_out_ready = (i % 2 == 0); cycle(); end
    tx_shift_busy = 0; tx_out_ready = 0; cycle();
    for (int i = 0; i < 10; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(8'h90 + i); tx_out_ready = (i > 3); cycle();
    end
    tx_in_valid = 0; tx_out_ready = 0;

    // flush on falling enable with an arrival (R4)
    for (int i = 0; i < 5; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(i); tx_in_valid = 1; tx_in_data = 8'(8'hC0 + i); cycle();
    end
    cfg_fifo_en = 0; rx_in_data = 8'h77; cycle();
    rx_in_valid = 0; tx_in_valid = 0; cycle(); cycle();

    // random overlap of all functions
    for (int n = 0; n < 3000; n++) begin
      tx_in_valid   = 1'($urandom % 2);
      tx_in_data    = 8'($urandom);
      tx_out_ready  = ($urandom % 3) == 0;
      tx_shift_busy = ($urandom % 4) == 0;
      rx_in_valid   = ($urandom % 5) == 0;
      rx_in_data    = 8'($urandom);
      rx_in_err     = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      rx_bit_tick   = ($urandom % 2) == 0;
      rx_out_ready  = ((n / 200) % 2 == 0) ? (($urandom % 3) == 0) : 1'b0;
      irq_clr       = (($urandom % 8) == 0) ? 7'($urandom) : 7'h00;
      if (n % 64 == 0)  irq_mask = 7'($urandom);
      if (n % 100 == 0) begin cfg_tx_lvl = 3'($urandom); cfg_rx_lvl = 3'($urandom); end
      if (n % 450 == 0) cfg_fifo_en = !cfg_fifo_en;
      cycle();
    end

    idle_inputs();
    cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule